// File: doc/BRIEF.md
# Stereo Dither Injector

This block sits in front of the truncation stage of an oversampling DAC modulator. It adds a small pseudo-random value to each high-resolution stereo sample. The random term breaks the correlation between the signal and the truncation error, so that error no longer collects into audible idle tones.

A 2-bit level code selects one of four settings: no dither, or one of three dither powers spaced about 3 dB apart. Samples arrive with a single valid strobe shared by both channels. Each channel takes its random word from its own linear-feedback generator, so the left and right dither are uncorrelated. The sum is saturated to the sample width, and the result is presented one clock later. It is held until the next valid sample arrives.

Top module: `dither_injector`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid sample is taken, `out_valid` is 0 and both output samples are 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, both output samples keep their previous values.
- R3: Level code 2'b00 adds nothing: each output equals its input sample exactly.
- R4: Each channel has a 24-bit Fibonacci generator. Its next state is `{s[22:0], s[23]^s[22]^s[21]^s[16]}`. The left generator resets to 24'h000001 and the right one to 24'hA5A5A5. Each generator advances once per valid sample, whatever the level code. The random word `r` is the low 8 bits of the state before that advance, read as two's complement.
- R5: Level code 2'b01 uses dither `d = r`.
- R6: Level code 2'b10 uses dither `d = r + (r>>>2) + (r>>>3) + (r>>>5)`, with floor shifts. This gives a gain of about 1.406, or 3 dB above code 2'b01.
- R7: Level code 2'b11 uses dither `d = 2*r`, which is 6 dB above code 2'b01.
- R8: The dither is added at a weight of 16, so the output is the saturated value of `x + 16*d`, where x is the signed 24-bit input.
- R9: A sum above 24'h7FFFFF gives 24'h7FFFFF, and a sum below -8388608 gives 24'h800000. The sum never wraps.
- R10: The level code is sampled together with the valid sample. Changing it between valid samples does not alter the held output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Qualifies both input samples and the level code |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| mode | input | 2 | Dither level code |
| out_valid | output | 1 | Output samples updated this cycle |
| out_left | output | 24 | Dithered, saturated left sample |
| out_right | output | 24 | Dithered, saturated right sample |

## Verification
Every result is registered once, so the outputs and `out_valid` for a sample taken at one rising edge are valid from that edge until the next valid sample arrives. The bench drives each sample at a falling edge and checks the corresponding output at the following falling edge. It keeps its own copies of both generators and advances them only after a valid sample has been checked. Idle cycles with a changed level code are checked at the same point, against the value that was held before.

// File: rtl/dither_pkg.sv
package dither_pkg;
  typedef enum logic [1:0] {
    DITH_OFF  = 2'b00,
    DITH_LOW  = 2'b01,
    DITH_MID  = 2'b10,
    DITH_HIGH = 2'b11
  } dith_mode_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dither_lfsr.sv
module dither_lfsr #(
  parameter int unsigned   W     = 24,
  parameter logic [W-1:0]  TAPS  = 24'hE10000,
  parameter logic [W-1:0]  SEED  = 24'h000001,
  parameter int unsigned   OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (adv) begin
      state_d = {state_q[W-2:0], ^(state_q & TAPS)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign rnd = state_q[OUT_W-1:0];

  assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  assert_lfsr_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q));

  assert_lfsr_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> state_q != $past(state_q));
endmodule

// File: rtl/dither_scaler.sv
module dither_scaler
  import dither_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned SW = DW + 2
) (
  input  logic [DW-1:0]        rnd,
  input  logic [1:0]           mode,
  output logic signed [SW-1:0] dith
);
  logic signed [SW-1:0] r;

  assign r = {{2{rnd[DW-1]}}, rnd};

  always_comb begin
    unique case (dith_mode_e'(mode))
      DITH_OFF:  dith = '0;
      DITH_LOW:  dith = r;
      DITH_MID:  dith = r + (r >>> 2) + (r >>> 3) + (r >>> 5);
      DITH_HIGH: dith = r <<< 1;
      default:   dith = '0;
    endcase
  end
endmodule

// File: rtl/dither_sat_add.sv
module dither_sat_add #(
  parameter int unsigned XW    = 24,
  parameter int unsigned DW    = 10,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned SUMW = XW + 1
) (
  input  logic signed [XW-1:0] x,
  input  logic signed [DW-1:0] d,
  output logic [XW-1:0]        y
);
  logic signed [SUMW-1:0] x_w;
  logic signed [SUMW-1:0] d_w;
  logic signed [SUMW-1:0] sum;

  assign x_w = {x[XW-1], x};
  assign d_w = {{(SUMW-DW){d[DW-1]}}, d} <<< SHIFT;
  assign sum = x_w + d_w;

  always_comb begin
    if (sum[SUMW-1] != sum[SUMW-2]) begin
      y = sum[SUMW-1] ? {1'b1, {(XW-1){1'b0}}} : {1'b0, {(XW-1){1'b1}}};
    end else begin
      y = sum[XW-1:0];
    end
  end
endmodule

// File: rtl/dither_injector.sv
module dither_injector
  import dither_pkg::*;
#(
  parameter int unsigned             SAMPLE_W     = 24,
  parameter int unsigned             LFSR_W       = 24,
  parameter logic [LFSR_W-1:0]       LFSR_TAPS    = 24'hE10000,
  parameter logic [LFSR_W-1:0]       SEED_L       = 24'h000001,
  parameter logic [LFSR_W-1:0]       SEED_R       = 24'hA5A5A5,
  parameter int unsigned             DITHER_W     = 8,
  parameter int unsigned             DITHER_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic [1:0]          mode,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  localparam int unsigned SCALED_W = DITHER_W + 2;

  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [SAMPLE_W-1:0]        smp_in  [NUM_CH];
  logic [SAMPLE_W-1:0]        smp_d   [NUM_CH];
  logic [SAMPLE_W-1:0]        smp_q   [NUM_CH];
  logic [SAMPLE_W-1:0]        summed  [NUM_CH];
  logic signed [SCALED_W-1:0] dith    [NUM_CH];
  logic [DITHER_W-1:0]        rnd     [NUM_CH];
  logic                       valid_q;
  logic                       valid_d;

  assign smp_in[0] = in_left;
  assign smp_in[1] = in_right;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [LFSR_W-1:0] CH_SEED = (ch == 0) ? SEED_L : SEED_R;

    dither_lfsr #(
      .W     (LFSR_W),
      .TAPS  (LFSR_TAPS),
      .SEED  (CH_SEED),
      .OUT_W (DITHER_W)
    ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .adv   (in_valid),
      .rnd   (rnd[ch])
    );

    dither_scaler #(
      .DW (DITHER_W)
    ) u_scale (
      .rnd  (rnd[ch]),
      .mode (mode),
      .dith (dith[ch])
    );

    dither_sat_add #(
      .XW    (SAMPLE_W),
      .DW    (SCALED_W),
      .SHIFT (DITHER_SHIFT)
    ) u_add (
      .x (smp_in[ch]),
      .d (dith[ch]),
      .y (summed[ch])
    );

    always_comb begin
      smp_d[ch] = smp_q[ch];
      if (in_valid) begin
        smp_d[ch] = summed[ch];
      end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        smp_q[ch] <= '0;
      end else begin
        smp_q[ch] <= smp_d[ch];
      end
    end

    assert_no_wrap_pos_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && !smp_in[ch][SAMPLE_W-1] && !dith[ch][SCALED_W-1])
        |=> !smp_q[ch][SAMPLE_W-1]);

    assert_no_wrap_neg_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && smp_in[ch][SAMPLE_W-1] && dith[ch][SCALED_W-1])
        |=> smp_q[ch][SAMPLE_W-1]);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !in_valid |=> $stable(smp_q[ch]));

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && mode == 2'b00) |=> smp_q[ch] == $past(smp_in[ch]));
  end

  assign valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign out_valid = valid_q;
  assign out_left  = smp_q[0];
  assign out_right = smp_q[1];

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
endmodule

// File: tb/dither_injector_test.sv
`timescale 1ns/1ps
module dither_injector_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_left;
  logic [23:0] in_right;
  logic [1:0]  mode;
  logic        out_valid;
  logic [23:0] out_left;
  logic [23:0] out_right;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [23:0] st_l = 24'h000001;
  logic [23:0] st_r = 24'hA5A5A5;
  logic [23:0] held_l = '0;
  logic [23:0] held_r = '0;

  always #2.5 clk = ~clk;

  dither_injector uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .mode      (mode),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );

  // R4 generator step
  function automatic logic [23:0] lfsr_next(input logic [23:0] s);
    return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

  // R5..R9 expected sample; clamp reports saturation
  function automatic logic [23:0] model(input logic [23:0] x, input logic [1:0] m,
                                        input logic [23:0] st, output bit clamp);
    int r;
    int d;
    longint s;
    r = int'($signed(st[7:0]));
    case (m)
      2'b00:   d = 0;
      2'b01:   d = r;
      2'b10:   d = r + (r >>> 2) + (r >>> 3) + (r >>> 5);
      default: d = r * 2;
    endcase
    s = longint'($signed(x)) + longint'(d) * 16;
    clamp = 1'b0;
    if (s > 64'sd8388607)  begin s = 64'sd8388607;  clamp = 1'b1; end
    if (s < -64'sd8388608) begin s = -64'sd8388608; clamp = 1'b1; end
    return s[23:0];
  endfunction

  function automatic string req_of(input logic [1:0] m, input bit clamp);
    if (clamp) return "R9";
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check at the next falling edge
  task automatic step(input bit v, input logic [23:0] l, input logic [23:0] r,
                      input logic [1:0] m);
    logic [23:0] el;
    logic [23:0] er;
    bit cl;
    bit cr;
    in_valid = v;
    in_left  = l;
    in_right = r;
    mode     = m;
    @(negedge clk);
    if (v) begin
      el = model(l, m, st_l, cl);
      er = model(r, m, st_r, cr);
      check("R2", {23'd0, out_valid}, 24'd1);
      check({req_of(m, cl), " R8 left"},  out_left,  el);
      check({req_of(m, cr), " R4 right"}, out_right, er);
      st_l = lfsr_next(st_l);
      st_r = lfsr_next(st_r);
      held_l = el;
      held_r = er;
    end else begin
      check("R2", {23'd0, out_valid}, 24'd0);
      check("R10 left hold",  out_left,  held_l);
      check("R10 right hold", out_right, held_r);
    end
  endtask

  initial begin
    logic [23:0] pats [8];
    pats[0] = 24'h7FFFFF; pats[1] = 24'h800000; pats[2] = 24'h000000;
    pats[3] = 24'h000001; pats[4] = 24'hFFFFFF; pats[5] = 24'h7FFF80;
    pats[6] = 24'h800070; pats[7] = 24'h123456;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_left  = '0;
    in_right = '0;
    mode     = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 valid", {23'd0, out_valid}, 24'd0);
    check("R1 left",  out_left,  24'd0);
    check("R1 right", out_right, 24'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after release", {23'd0, out_valid}, 24'd0);
    check("R1 left after release",  out_left,  24'd0);

    // every level code against every boundary pattern, back to back
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          step(1'b1, pats[a], pats[b], 2'(m));
        end
      end
    end

    // mixed stream with idle gaps and code changes between samples
    for (int i = 0; i < 600; i++) begin
      if (i % 7 == 3) begin
        step(1'b0, 24'(i * 24'h0F0F0F), 24'h55AA55, 2'(i + 1));
      end else begin
        step(1'b1, 24'(i * 24'h012345), 24'(24'hFFFFFF - i * 24'h00A3B1), 2'(i / 5));
      end
    end

    // generator keeps running under bypass, then dither resumes in step
    for (int i = 0; i < 40; i++) step(1'b1, 24'(i), 24'(-i), 2'b00);
    for (int i = 0; i < 40; i++) step(1'b1, 24'(i), 24'(-i), 2'b11);
    step(1'b0, 24'h0, 24'h0, 2'b00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule